// File: doc/BRIEF.md
# Coprocessor Test Timer with Interrupt Scheduling

This block sits beside a processor core as a test peripheral. It answers two coprocessor numbers and holds a bank of sixteen data registers. The core hands it operations over a command channel: register write, register read, word load, word store, or a data operation carrying a 4-bit function code. Each accepted operation is answered on a response channel with a status of done, busy or rejected, plus read data where the operation returns any.

The data operations do more than move values. Function 0 stalls the issuer for a number of cycles held in a register. On the second coprocessor number, further functions arm a delayed drop of the active-low fast or normal interrupt line, raise those lines again, or copy a free-running cycle counter into a register. All delays are measured against that counter with modular arithmetic, so they stay correct when it wraps.

The command channel uses valid/ready. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a stall is in progress. The response channel has no ready. Its result sits on the outputs for the single cycle in which `rsp_valid` is high, and the consumer must take it then. A stall shows one response per cycle: busy until the final cycle, which reports done. The command fields are sampled only in the accepting cycle.

Top module: `cp_test_timer`

## Requirements
- R1: After reset, `fiq_n` and `irq_n` are high, `cmd_ready` is high, `rsp_valid` is low, and every register reads as zero.
- R2: On coprocessor 4 or 5, op 0 (write) stores `cmd_wdata` into the register selected by instruction bits 19:16, and op 1 (read) returns that register on `rsp_rdata`. Each answers with status 0 (done) in the cycle after acceptance.
- R3: Op 2 (load) stores `cmd_wdata` and op 3 (store) returns the register, both using the register selected by bits 15:12. Both are accepted only on coprocessor 4. On coprocessor 5 they return status 2 (rejected) and change no register.
- R4: Op 4 (data) with function bits 23:20 equal to 0, on either number, is a stall of L cycles. L is the register selected by bits 3:0, truncated to the counter width. It produces exactly L responses with status 1 (busy), then one with status 0. L = 0 gives a single done. `cmd_ready` is low while busy is reported.
- R5: These commands return status 2 with zero read data and change no register or interrupt line: a nonzero function on coprocessor 4, functions 6 to 15 on coprocessor 5, any other coprocessor number, and op codes 5 to 7.
- R6: Function 1 on coprocessor 5, with delay N taken from the register selected by bits 3:0, drives `fiq_n` low N cycles after the accepting edge. N = 0 drives it low at the accepting edge.
- R7: Function 2 on coprocessor 5 does the same for `irq_n`.
- R8: Function 3 drives `fiq_n` high and function 4 drives `irq_n` high, both on coprocessor 5. Each also cancels any pending drop of its line.
- R9: Re-issuing function 1 or 2 while a drop is pending replaces the old delay. The line then falls N cycles after the newest command.
- R10: Function 5 on coprocessor 5 writes the cycle count sampled at the accepting edge, zero-extended, into the register selected by bits 3:0. The count is zero at the first edge after reset and rises by one each cycle.
- R11: The cycle counter wraps modulo 2^CNT_W, and stalls and interrupt delays that span the wrap still last exactly their programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command (low during a stall) |
| cmd_cp | input | 4 | Coprocessor number |
| cmd_op | input | 3 | Operation: 0 write, 1 read, 2 load, 3 store, 4 data |
| cmd_instr | input | 32 | Instruction fields (23:20 function, 19:16, 15:12 and 3:0 register selects) |
| cmd_wdata | input | DATA_W | Data for write and load |
| rsp_valid | output | 1 | Response present for this cycle |
| rsp_status | output | 2 | 0 done, 1 busy, 2 rejected |
| rsp_rdata | output | DATA_W | Read or store data, zero otherwise |
| fiq_n | output | 1 | Active-low fast interrupt |
| irq_n | output | 1 | Active-low normal interrupt |

## Verification
The bench builds the block with CNT_W = 12 and DATA_W = 32. With a 12-bit counter, the wrap at 4096 cycles is reachable in a short run. A stall and a fast-interrupt delay are started just before that boundary, and a timestamp is taken just after it. This exercises the modular deadline compare and the zero-extension of a narrow count into a 32-bit register, which the default 32-bit counter would never reach.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  typedef enum logic [2:0] {
    OP_WRITE = 3'd0,
    OP_READ  = 3'd1,
    OP_LOAD  = 3'd2,
    OP_STORE = 3'd3,
    OP_DATA  = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    ST_DONE   = 2'd0,
    ST_BUSY   = 2'd1,
    ST_REJECT = 2'd2
  } status_e;

  localparam logic [3:0] CP_MAIN = 4'd4;
  localparam logic [3:0] CP_INTR = 4'd5;

  localparam logic [3:0] FN_STALL    = 4'd0;
  localparam logic [3:0] FN_FIQ_ARM  = 4'd1;
  localparam logic [3:0] FN_IRQ_ARM  = 4'd2;
  localparam logic [3:0] FN_FIQ_DROP = 4'd3;
  localparam logic [3:0] FN_IRQ_DROP = 4'd4;
  localparam logic [3:0] FN_STAMP    = 4'd5;

  localparam int TMR_STALL = 0;
  localparam int TMR_FIQ   = 1;
  localparam int TMR_IRQ   = 2;
  localparam int NUM_TMR   = 3;
endpackage

// File: rtl/cpt_regbank.sv
module cpt_regbank #(
  parameter int DATA_W = 32,
  parameter int NREG   = 16,
  parameter int NRD    = 3,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             widx,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [NRD-1:0][IDX_W-1:0]    ridx,
  output logic [NRD-1:0][DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && widx == IDX_W'(g))
        regs[g] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = regs[ridx[p]];
  end
endmodule

// File: rtl/cpt_deadline.sv
module cpt_deadline #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] now,
  input  logic             arm,
  input  logic [CNT_W-1:0] len,
  input  logic             cancel,
  output logic             pending,
  output logic             expire
);
  logic [CNT_W-1:0] t0;
  logic [CNT_W-1:0] lim;

  // modular elapsed time survives counter wrap
  assign expire = pending && ((now - t0) >= lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      t0      <= '0;
      lim     <= '0;
    end else if (arm) begin
      pending <= (len != '0);
      t0      <= now;
      lim     <= len;
    end else if (cancel || expire) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/cp_test_timer.sv
module cp_test_timer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_cp,
  input  logic [2:0]        cmd_op,
  input  logic [31:0]       cmd_instr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              fiq_n,
  output logic              irq_n
);
  import cpt_pkg::*;

  localparam int NREG  = 16;
  localparam int IDX_W = $clog2(NREG);
  localparam int NRD   = 3;
  localparam int RD_MV = 0;
  localparam int RD_LS = 1;
  localparam int RD_DP = 2;

  logic [CNT_W-1:0] cyc;
  logic             acc;
  logic             on_main, on_intr, cp_ok;
  logic [3:0]       fn;
  logic [NRD-1:0][IDX_W-1:0]  ridx;
  logic [NRD-1:0][DATA_W-1:0] rval;
  logic [CNT_W-1:0] dp_len;

  logic              d_we;
  logic [IDX_W-1:0]  d_widx;
  logic [DATA_W-1:0] d_wdata;
  status_e           d_status;
  logic [DATA_W-1:0] d_rdata;
  logic [NUM_TMR-1:0] d_arm, d_cancel;
  logic [NUM_TMR-1:0] t_arm, t_cancel, t_pend, t_exp;

  assign acc     = cmd_valid && cmd_ready;
  assign on_main = (cmd_cp == CP_MAIN);
  assign on_intr = (cmd_cp == CP_INTR);
  assign cp_ok   = on_main || on_intr;
  assign fn      = cmd_instr[23:20];
  assign ridx[RD_MV] = cmd_instr[19:16];
  assign ridx[RD_LS] = cmd_instr[15:12];
  assign ridx[RD_DP] = cmd_instr[3:0];
  assign dp_len  = rval[RD_DP][CNT_W-1:0];
  assign cmd_ready = !t_pend[TMR_STALL];

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 1'b1;
  end

  always_comb begin
    d_we     = 1'b0;
    d_widx   = ridx[RD_MV];
    d_wdata  = cmd_wdata;
    d_status = ST_REJECT;
    d_rdata  = '0;
    d_arm    = '0;
    d_cancel = '0;
    unique case (cmd_op)
      OP_WRITE: if (cp_ok) begin
        d_we = 1'b1;
        d_status = ST_DONE;
      end
      OP_READ: if (cp_ok) begin
        d_rdata = rval[RD_MV];
        d_status = ST_DONE;
      end
      OP_LOAD: if (on_main) begin
        d_we = 1'b1;
        d_widx = ridx[RD_LS];
        d_status = ST_DONE;
      end
      OP_STORE: if (on_main) begin
        d_rdata = rval[RD_LS];
        d_status = ST_DONE;
      end
      OP_DATA: if (cp_ok) begin
        if (fn == FN_STALL) begin
          d_arm[TMR_STALL] = 1'b1;
          d_status = (dp_len == '0) ? ST_DONE : ST_BUSY;
        end else if (on_intr) begin
          d_status = ST_DONE;
          unique case (fn)
            FN_FIQ_ARM:  d_arm[TMR_FIQ] = 1'b1;
            FN_IRQ_ARM:  d_arm[TMR_IRQ] = 1'b1;
            FN_FIQ_DROP: d_cancel[TMR_FIQ] = 1'b1;
            FN_IRQ_DROP: d_cancel[TMR_IRQ] = 1'b1;
            FN_STAMP: begin
              d_we = 1'b1;
              d_widx = ridx[RD_DP];
              d_wdata = DATA_W'(cyc);
            end
            default: d_status = ST_REJECT;
          endcase
        end
      end
      default: ;
    endcase
  end

  assign t_arm    = acc ? d_arm : '0;
  assign t_cancel = acc ? d_cancel : '0;

  cpt_regbank #(.DATA_W(DATA_W), .NREG(NREG), .NRD(NRD)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (acc && d_we),
    .widx  (d_widx),
    .wdata (d_wdata),
    .ridx  (ridx),
    .rdata (rval)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    cpt_deadline #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .now     (cyc),
      .arm     (t_arm[g]),
      .len     (dp_len),
      .cancel  (t_cancel[g]),
      .pending (t_pend[g]),
      .expire  (t_exp[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fiq_n <= 1'b1;
      irq_n <= 1'b1;
    end else begin
      if (t_cancel[TMR_FIQ])                    fiq_n <= 1'b1;
      else if (t_arm[TMR_FIQ] && dp_len == '0)  fiq_n <= 1'b0;
      else if (t_exp[TMR_FIQ] && !t_arm[TMR_FIQ]) fiq_n <= 1'b0;
      if (t_cancel[TMR_IRQ])                    irq_n <= 1'b1;
      else if (t_arm[TMR_IRQ] && dp_len == '0)  irq_n <= 1'b0;
      else if (t_exp[TMR_IRQ] && !t_arm[TMR_IRQ]) irq_n <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_DONE;
      rsp_rdata  <= '0;
    end else if (acc) begin
      rsp_valid  <= 1'b1;
      rsp_status <= d_status;
      rsp_rdata  <= d_rdata;
    end else if (t_pend[TMR_STALL]) begin
      rsp_valid  <= 1'b1;
      rsp_status <= t_exp[TMR_STALL] ? ST_DONE : ST_BUSY;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_DONE;
      rsp_rdata  <= '0;
    end
  end
endmodule

// File: rtl/cpt_checker.sv
module cpt_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [3:0]        cmd_cp,
  input logic [2:0]        cmd_op,
  input logic [31:0]       cmd_instr,
  input logic [DATA_W-1:0] cmd_wdata,
  input logic              rsp_valid,
  input logic [1:0]        rsp_status,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              fiq_n,
  input logic              irq_n
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  a_r4_busy_blocks_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd1) |-> !cmd_ready);

  a_r2_rsp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(acc) || $past(rsp_valid && rsp_status == 2'd1)));

  a_r5_foreign_cp_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_cp != 4'd4 && cmd_cp != 4'd5) |=> (rsp_valid && rsp_status == 2'd2));

  a_r5_reject_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd2) |-> (rsp_rdata == '0));

  a_r3_ldst_cp5_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_cp == 4'd5 && (cmd_op == 3'd2 || cmd_op == 3'd3)) |=> (rsp_valid && rsp_status == 2'd2));

  a_r8_fiq_release: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_cp == 4'd5 && cmd_op == 3'd4 && cmd_instr[23:20] == 4'd3) |=> fiq_n);

  a_r8_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_cp == 4'd5 && cmd_op == 3'd4 && cmd_instr[23:20] == 4'd4) |=> irq_n);
endmodule

bind cp_test_timer cpt_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cp_test_timer_tb.sv
`timescale 1ns/1ps
module cp_test_timer_tb;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 12;
  localparam int MOD    = 1 << CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [3:0] cmd_cp = '0;
  logic [2:0] cmd_op = '0;
  logic [31:0] cmd_instr = '0;
  logic [DATA_W-1:0] cmd_wdata = '0;
  logic rsp_valid;
  logic [1:0] rsp_status;
  logic [DATA_W-1:0] rsp_rdata;
  logic fiq_n, irq_n;

  int nchk = 0;
  int nerr = 0;
  int mcyc = 0;
  bit done_flag = 0;
  logic rv;
  logic [1:0] rs;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  always @(posedge clk) mcyc <= rst_n ? (mcyc + 1) % MOD : 0;

  cp_test_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ins(input int fn, input int a, input int b, input int c);
    return (32'(fn) << 20) | (32'(a) << 16) | (32'(b) << 12) | 32'(c);
  endfunction

  task automatic issue(input int cp, input int op, input logic [31:0] instr, input logic [31:0] wd);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_cp = 4'(cp); cmd_op = 3'(op); cmd_instr = instr; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    rv = rsp_valid; rs = rsp_status; rd = rsp_rdata;
  endtask

  task automatic wr(input int cp, input int idx, input logic [31:0] v);
    issue(cp, 0, ins(0, idx, 0, 0), v);
  endtask

  task automatic rd_reg(input int idx, output logic [31:0] v);
    issue(4, 1, ins(0, idx, 0, 0), 0);
    v = rd;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk(fiq_n && irq_n, "R1 lines high", {fiq_n, irq_n}, 2'b11);
    chk(cmd_ready && !rsp_valid, "R1 ready/idle", {cmd_ready, rsp_valid}, 2'b10);
    rd_reg(7, v);
    chk(v == 0, "R1 reg zero", v, 0);
  endtask

  task automatic t_regs;
    wr(4, 3, 32'hA5A5_1234);
    chk(rv && rs == 0, "R2 write done", rs, 0);
    issue(5, 1, ins(0, 3, 0, 0), 0);
    chk(rv && rs == 0 && rd == 32'hA5A5_1234, "R2 read via cp5", rd, 32'hA5A5_1234);
    wr(5, 15, 32'hDEAD_0F0F);
    issue(4, 1, ins(0, 15, 0, 0), 0);
    chk(rd == 32'hDEAD_0F0F, "R2 read reg15", rd, 32'hDEAD_0F0F);
  endtask

  task automatic t_ldst;
    logic [31:0] v;
    issue(4, 2, ins(0, 1, 9, 2), 32'h0BAD_CAFE);
    chk(rv && rs == 0, "R3 load done", rs, 0);
    issue(4, 3, ins(0, 2, 9, 1), 0);
    chk(rv && rs == 0 && rd == 32'h0BAD_CAFE, "R3 store data", rd, 32'h0BAD_CAFE);
    issue(5, 2, ins(0, 0, 9, 0), 32'h1111_1111);
    chk(rv && rs == 2, "R3 load cp5 rejected", rs, 2);
    issue(5, 3, ins(0, 0, 9, 0), 0);
    chk(rv && rs == 2 && rd == 0, "R3 store cp5 rejected", rd, 0);
    rd_reg(9, v);
    chk(v == 32'h0BAD_CAFE, "R3 reg unchanged", v, 32'h0BAD_CAFE);
  endtask

  task automatic t_stall(input int cp, input int len, input string tag);
    int nb = 0;
    int guard = 0;
    wr(4, 6, len);
    issue(cp, 4, ins(0, 0, 0, 6), 0);
    while (rv && rs == 1 && guard < 2000) begin
      if (cmd_ready) chk(0, "R4 ready low while busy", cmd_ready, 0);
      nb++; guard++;
      rv = rsp_valid; rs = rsp_status;
      @(negedge clk);
      rv = rsp_valid; rs = rsp_status;
    end
    chk(rv && rs == 0, {tag, " final done"}, rs, 0);
    chk(nb == len, {tag, " busy count"}, nb, len);
  endtask

  task automatic t_reject;
    logic [31:0] v;
    wr(4, 0, 0);
    issue(4, 4, ins(1, 0, 0, 0), 0);
    chk(rv && rs == 2, "R5 cp4 fn1 rejected", rs, 2);
    chk(fiq_n, "R5 cp4 fn1 no fiq", fiq_n, 1);
    issue(5, 4, ins(6, 0, 0, 0), 0);
    chk(rv && rs == 2, "R5 cp5 fn6 rejected", rs, 2);
    issue(5, 4, ins(15, 0, 0, 0), 0);
    chk(rv && rs == 2, "R5 cp5 fn15 rejected", rs, 2);
    issue(7, 0, ins(0, 3, 0, 0), 32'h5555_5555);
    chk(rv && rs == 2 && rd == 0, "R5 cp7 rejected", rs, 2);
    issue(4, 5, ins(0, 3, 0, 0), 32'h6666_6666);
    chk(rv && rs == 2, "R5 op5 rejected", rs, 2);
    rd_reg(3, v);
    chk(v == 32'hA5A5_1234, "R5 reg3 untouched", v, 32'hA5A5_1234);
  endtask

  task automatic t_line(input bit is_fiq, input int n);
    string tg = is_fiq ? "R6" : "R7";
    wr(4, 8, n);
    issue(5, 4, ins(is_fiq ? 1 : 2, 0, 0, 8), 0);
    for (int k = 0; k < n; k++) begin
      if (!(is_fiq ? fiq_n : irq_n)) chk(0, {tg, " early low"}, k, n);
      @(negedge clk);
    end
    chk(!(is_fiq ? fiq_n : irq_n), {tg, " low at deadline"}, is_fiq ? fiq_n : irq_n, 0);
    issue(5, 4, ins(is_fiq ? 3 : 4, 0, 0, 0), 0);
    chk(is_fiq ? fiq_n : irq_n, "R8 release high", 0, 1);
  endtask

  task automatic t_cancel;
    wr(4, 8, 10);
    issue(5, 4, ins(2, 0, 0, 8), 0);
    repeat (2) @(negedge clk);
    issue(5, 4, ins(4, 0, 0, 0), 0);
    repeat (15) @(negedge clk);
    chk(irq_n, "R8 cancel pending irq", irq_n, 1);
  endtask

  task automatic t_reload;
    wr(4, 8, 3);
    wr(4, 10, 6);
    issue(5, 4, ins(1, 0, 0, 8), 0);
    issue(5, 4, ins(1, 0, 0, 10), 0);
    repeat (5) @(negedge clk);
    chk(fiq_n, "R9 old deadline dropped", fiq_n, 1);
    @(negedge clk);
    chk(!fiq_n, "R9 new deadline", fiq_n, 0);
    issue(5, 4, ins(3, 0, 0, 0), 0);
  endtask

  task automatic t_stamp(input string tag);
    logic [31:0] exp, v;
    issue(5, 4, ins(5, 0, 0, 11), 0);
    exp = 32'((mcyc + MOD - 1) % MOD);
    chk(rv && rs == 0, {tag, " stamp done"}, rs, 0);
    rd_reg(11, v);
    chk(v == exp, {tag, " stamp value"}, v, exp);
  endtask

  task automatic t_wrap;
    while (mcyc != MOD - 8) @(negedge clk);
    t_stall(4, 20, "R11 stall across wrap");
    while (mcyc != MOD - 30) @(negedge clk);
    t_line(1, 40);
    t_stamp("R11");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_ldst();
    t_stall(4, 0, "R4 zero stall");
    t_stall(4, 5, "R4 cp4 stall");
    t_stall(5, 3, "R4 cp5 stall");
    t_reject();
    t_line(1, 4);
    t_line(1, 0);
    t_line(0, 7);
    t_line(0, 0);
    t_cancel();
    t_reload();
    t_stamp("R10");
    t_wrap();
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule